// File: doc/BRIEF.md
# Multiplexed-Bus Synchronous Burst Write Receiver

This block sits on the device side of a 16-bit multiplexed address/data bus. An external host drives the bus synchronously to a free-running bus clock. The receiver demultiplexes that bus into a clean write stream for internal registers.

While chip select and address valid are both low, the block latches the word address from the shared lines. On each later clock edge where write enable is low, it takes the bus value as one data word. Within one chip-select assertion the word address steps by one for every word taken, so a 32-bit host write appears as two writes to consecutive word addresses. Each word is presented for exactly one cycle on a valid/address/data output.

A monitor counts how many cycles chip select stays low during an access. It raises a flag when the strobes are held longer than the expected burst allows. This catches hosts that stretch their control signals by an unexpected extra cycle.

Top module: `mux_burst_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `wrValid`, `wrAddr`, `wrData` and `holdViol` are all zero.
- R2: On every rising edge where `csN` and `advN` are both sampled low, the low `ADDR_W` bits of `adBus` become the current word address. If address valid is held for several edges, the last sampled value wins.
- R3: After an address phase, on the first rising edge where `csN` is low, `advN` is high and `weN` is low, `adBus` is taken as a data word. In the following cycle `wrValid` is 1, `wrAddr` equals the latched address and `wrData` equals the sampled bus value.
- R4: Each further edge in the same access with `csN` low, `advN` high and `weN` low takes another word. That word is presented at the previous word's address plus one.
- R5: `wrValid` is high for exactly one cycle per word taken, and low in every other cycle.
- R6: A write-enable-low edge without a preceding address phase in the current chip-select assertion produces no write. This includes an address-valid pulse sampled while `csN` was high.
- R7: An edge with `csN` high returns the receiver to idle. A following chip-select assertion produces no write until a new address phase is seen.
- R8: `holdViol` goes high one cycle after the edge on which `csN` has been sampled low for more than `MAX_BEATS + SETUP_CYCLES` consecutive edges (default 2 + 2 = 4). It stays high while `csN` remains low and is 0 in the cycle after any edge with `csN` high.
- R9: An edge in the data phase with `weN` high (and `csN` low) takes no word and leaves the word address unchanged for the next word.
- R10: An address phase seen during an access that already carries data reloads the word address. Later words continue from the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Continuous bus clock; all strobes sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| advN | input | 1 | Active-low address valid |
| weN | input | 1 | Active-low write enable |
| adBus | input | 16 | Multiplexed address/data lines |
| wrValid | output | 1 | One-cycle pulse per received word |
| wrAddr | output | 16 | Word address of the received word |
| wrData | output | 16 | Received data word |
| holdViol | output | 1 | Chip select held low longer than the allowed burst |

## Verification
The directed patterns cover:
- a single-word write, which tells a correct one-beat capture apart from a stray second beat;
- a two-beat burst, which exposes a missing or wrong address increment;
- a burst with a write-enable gap, which separates "increment per word" from "increment per cycle";
- a stretched chip select, which shows whether the violation flag fires exactly one cycle past the limit and not earlier.

Stray write-enable or address-valid pulses outside a proper address phase check that the idle state really blocks captures. Randomly sized accesses with random addresses, data, gaps and extra hold cycles then check the whole stream against a cycle model kept in the bench.

// File: rtl/mbrx_pkg.sv
package mbrx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_ADDR = 2'd1,
    RX_DATA = 2'd2
  } rxState_t;

  typedef struct packed {
    logic loadAddr;
    logic captureBeat;
  } rxStrobes_t;

endpackage

// File: rtl/mbrx_ctrl.sv
module mbrx_ctrl
  import mbrx_pkg::*;
#(
  parameter int MAX_BEATS    = 2,
  parameter int SETUP_CYCLES = 2
) (
  input  logic       busClk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       advN,
  input  logic       weN,
  output rxStrobes_t strobes,
  output logic       holdViol
);

  localparam int LIMIT = MAX_BEATS + SETUP_CYCLES;
  localparam int CNT_W = $clog2(LIMIT + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LIMIT);

  rxState_t         state, stateNext;
  logic [CNT_W-1:0] csCount, csCountNext;

  // Strobe decode for the datapath
  always_comb begin
    strobes.loadAddr    = !csN && !advN;
    strobes.captureBeat = !csN && advN && !weN && (state != RX_IDLE);
  end

  always_comb begin
    stateNext = state;
    if (csN)                      stateNext = RX_IDLE;
    else if (strobes.loadAddr)    stateNext = RX_ADDR;
    else if (strobes.captureBeat) stateNext = RX_DATA;
  end

  // Saturating count of consecutive chip-select-low samples
  always_comb begin
    if (csN)                    csCountNext = '0;
    else if (csCount == CNT_SAT) csCountNext = csCount;
    else                        csCountNext = csCount + 1'b1;
  end

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      state    <= RX_IDLE;
      csCount  <= '0;
      holdViol <= 1'b0;
    end else begin
      state    <= stateNext;
      csCount  <= csCountNext;
      holdViol <= csCountNext > CNT_LIM;
    end
  end

  AST_VIOL_CLEARS: assert property (@(posedge busClk) disable iff (!rstN)
    $past(csN) |-> !holdViol); // R8

  AST_VIOL_NEEDS_CS: assert property (@(posedge busClk) disable iff (!rstN)
    holdViol |-> !$past(csN)); // R8

  AST_NO_CAPTURE_IDLE: assert property (@(posedge busClk) disable iff (!rstN)
    $past(csN) && advN |-> !strobes.captureBeat); // R7

endmodule

// File: rtl/mbrx_datapath.sv
module mbrx_datapath
  import mbrx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              busClk,
  input  logic              rstN,
  input  rxStrobes_t        strobes,
  input  logic [DATA_W-1:0] adBus,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  logic [ADDR_W-1:0] curAddr;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrValid <= strobes.captureBeat;
      if (strobes.loadAddr) begin
        curAddr <= adBus[ADDR_W-1:0];
      end else if (strobes.captureBeat) begin
        curAddr <= curAddr + 1'b1;
        wrAddr  <= curAddr;
        wrData  <= adBus;
      end
    end
  end

  AST_ADDR_STEP: assert property (@(posedge busClk) disable iff (!rstN)
    wrValid && $past(wrValid) |-> wrAddr == $past(wrAddr) + 1'b1); // R4

  AST_VALID_FROM_STROBE: assert property (@(posedge busClk) disable iff (!rstN)
    wrValid |-> $past(strobes.captureBeat)); // R5

endmodule

// File: rtl/mux_burst_rx.sv
module mux_burst_rx
  import mbrx_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 16,
  parameter int MAX_BEATS    = 2,
  parameter int SETUP_CYCLES = 2
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              advN,
  input  logic              weN,
  input  logic [DATA_W-1:0] adBus,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              holdViol
);

  rxStrobes_t strobes;

  mbrx_ctrl #(
    .MAX_BEATS   (MAX_BEATS),
    .SETUP_CYCLES(SETUP_CYCLES)
  ) uCtrl (
    .busClk  (busClk),
    .rstN    (rstN),
    .csN     (csN),
    .advN    (advN),
    .weN     (weN),
    .strobes (strobes),
    .holdViol(holdViol)
  );

  mbrx_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) uData (
    .busClk (busClk),
    .rstN   (rstN),
    .strobes(strobes),
    .adBus  (adBus),
    .wrValid(wrValid),
    .wrAddr (wrAddr),
    .wrData (wrData)
  );

  AST_WRITE_NEEDS_WE: assert property (@(posedge busClk) disable iff (!rstN)
    wrValid |-> $past(!csN && advN && !weN)); // R3

  AST_IDLE_NO_WRITE: assert property (@(posedge busClk) disable iff (!rstN)
    $past(csN) |-> !wrValid); // R7

endmodule

// File: tb/tb_mux_burst_rx.sv
module tb_mux_burst_rx;

  localparam int LIMIT = 4;

  logic        busClk = 1'b0;
  logic        rstN   = 1'b0;
  logic        csN    = 1'b1;
  logic        advN   = 1'b1;
  logic        weN    = 1'b1;
  logic [15:0] adBus  = '0;
  logic        wrValid;
  logic [15:0] wrAddr;
  logic [15:0] wrData;
  logic        holdViol;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // Bench model state
  bit          mActive = 0;
  logic [15:0] mAddr   = '0;
  int          mCnt    = 0;
  bit          eValid  = 0;
  logic [15:0] eAddr   = '0;
  logic [15:0] eData   = '0;
  bit          eViol   = 0;

  always #10 busClk = ~busClk;

  mux_burst_rx dut (
    .busClk  (busClk),
    .rstN    (rstN),
    .csN     (csN),
    .advN    (advN),
    .weN     (weN),
    .adBus   (adBus),
    .wrValid (wrValid),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .holdViol(holdViol)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void modelStep(input bit c, input bit a, input bit w, input logic [15:0] d);
    eValid = 0;
    if (c) begin
      mActive = 0;
      mCnt    = 0;
      eViol   = 0;
    end else begin
      if (mCnt <= LIMIT) mCnt++;
      eViol = (mCnt > LIMIT);
      if (!a) begin
        mAddr   = d;
        mActive = 1;
      end else if (!w && mActive) begin
        eValid = 1;
        eAddr  = mAddr;
        eData  = d;
        mAddr  = mAddr + 16'd1;
      end
    end
  endfunction

  // Drive at a falling edge, let one rising edge pass, compare at the next falling edge
  task automatic step(input bit c, input bit a, input bit w, input logic [15:0] d, input string tag);
    csN = c; advN = a; weN = w; adBus = d;
    modelStep(c, a, w, d);
    @(posedge busClk);
    @(negedge busClk);
    check({tag, " valid"}, {15'd0, wrValid}, {15'd0, eValid});
    if (eValid) begin
      check({tag, " addr"}, wrAddr, eAddr);
      check({tag, " data"}, wrData, eData);
    end
    check("R8 holdViol", {15'd0, holdViol}, {15'd0, eViol});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 1, 16'hFFFF, "R7 idle");
  endtask

  initial begin
    repeat (200000) @(posedge busClk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge busClk);
    check("R1 valid", {15'd0, wrValid}, 16'd0);
    check("R1 addr", wrAddr, 16'd0);
    check("R1 data", wrData, 16'd0);
    check("R1 viol", {15'd0, holdViol}, 16'd0);
    rstN = 1'b1;
    @(negedge busClk);
    check("R1 post", {15'd0, wrValid | holdViol}, 16'd0);

    // Single-word write
    step(0, 0, 1, 16'h0040, "R2 addr");
    step(0, 1, 0, 16'hA5A5, "R3 single");
    step(1, 1, 1, 16'h0000, "R5 after");
    idle(1);

    // Two-beat burst
    step(0, 0, 1, 16'h1000, "R2 addr");
    step(0, 1, 0, 16'h1111, "R3 beat1");
    step(0, 1, 0, 16'h2222, "R4 beat2");
    step(1, 1, 1, 16'h0000, "R5 end");

    // Address valid held two edges: last wins
    step(0, 0, 1, 16'h0AAA, "R2 first");
    step(0, 0, 1, 16'h0BBB, "R2 last");
    step(0, 1, 0, 16'h3333, "R2 beat");
    idle(1);

    // Write enable without address phase
    step(0, 1, 0, 16'h4444, "R6 noaddr");
    step(0, 1, 0, 16'h5555, "R6 noaddr2");
    idle(1);
    step(1, 0, 1, 16'h0123, "R6 advcshigh");
    step(0, 1, 0, 16'h6666, "R6 strayadv");
    idle(1);

    // Chip select drop mid-burst
    step(0, 0, 1, 16'h2000, "R2 addr");
    step(0, 1, 0, 16'h7777, "R3 beat");
    step(1, 1, 0, 16'h8888, "R7 drop");
    step(0, 1, 0, 16'h9999, "R7 resume");
    idle(1);

    // Gap inside burst
    step(0, 0, 1, 16'h3000, "R2 addr");
    step(0, 1, 0, 16'hC001, "R3 beat");
    step(0, 1, 1, 16'hDEAD, "R9 gap");
    step(0, 1, 0, 16'hC002, "R9 after gap");
    idle(1);

    // Re-address mid access
    step(0, 0, 1, 16'h4000, "R2 addr");
    step(0, 1, 0, 16'hE001, "R3 beat");
    step(0, 0, 1, 16'h5000, "R10 reload");
    step(0, 1, 0, 16'hE002, "R10 beat");
    idle(1);

    // Hold limit: exactly LIMIT low samples is allowed, one more flags
    step(0, 0, 1, 16'h6000, "R8 a");
    step(0, 1, 0, 16'hF001, "R8 b1");
    step(0, 1, 0, 16'hF002, "R8 b2");
    step(0, 1, 1, 16'h0000, "R8 s4");
    step(0, 1, 1, 16'h0000, "R8 s5");
    step(0, 1, 1, 16'h0000, "R8 s6");
    step(1, 1, 1, 16'h0000, "R8 clear");

    // Random accesses
    for (int n = 0; n < 400; n++) begin
      int beats = 1 + int'($urandom_range(2, 0));
      int extra = int'($urandom_range(3, 0));
      if ($urandom_range(7, 0) == 0) step(0, 1, 0, 16'($urandom), "R6 rnd stray");
      step(0, 0, 1, 16'($urandom), "R2 rnd addr");
      for (int b = 0; b < beats; b++) begin
        if ($urandom_range(3, 0) == 0) step(0, 1, 1, 16'($urandom), "R9 rnd gap");
        step(0, 1, 0, 16'($urandom), "R4 rnd beat");
      end
      for (int e = 0; e < extra; e++) step(0, 1, 1, 16'($urandom), "R8 rnd hold");
      idle(1 + int'($urandom_range(1, 0)));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule